// File: doc/BRIEF.md
# Cache Line Reuse Class Tracker

This block sits beside a private second-level cache and keeps a small reuse history for every line slot. The cache controller reports four kinds of events by line index: a fill (with a flag saying whether the data came from a last-level hit, the class value carried with the data, and a prefetch flag), a demand hit, a write that makes the line dirty, and an eviction. When a valid line is evicted, the tracker resolves the history gathered during that residency into one of five reuse classes. It presents that class one cycle later, together with the line's dirty status.

Each slot is a small state machine with four states. `LN_EMPTY` means no line is resident. `LN_PLAIN` means filled on demand with no hit since. `LN_PREF` means filled by a prefetch with no demand hit since. `LN_REUSED` means at least one demand hit during this residency. The transitions are as follows. *install* goes from any state to `LN_PLAIN` or `LN_PREF` on a fill. *reuse* goes from `LN_PLAIN` or `LN_PREF` to `LN_REUSED` on a demand hit. *retire* goes from any state to `LN_EMPTY` on an eviction without a same-cycle fill. *hold* covers every other cycle. Beside the state, each slot keeps a dirty bit and a sticky outer-reuse bit. The class codes, from highest priority down, are: 4 (outer reuse), 3 (demand reused), 0 (prefetched, never demanded), 2 (dirty, no hit) and 1 (clean, no hit).

Top module: `reuse_class_tracker`

## Requirements
- R1: After reset every slot is empty and `ev_valid` stays 0, including for an eviction request to a slot that was never filled.
- R2: An eviction request on a valid slot produces `ev_valid`=1 for exactly one cycle, in the cycle after the request, with `ev_line` equal to the requested index. No request means no pulse.
- R3: A slot that was demand-filled, never hit, never written and never marked for outer reuse resolves to class code 1 with `ev_dirty`=0.
- R4: A demand-filled slot that was written but never hit resolves to class code 2 with `ev_dirty`=1.
- R5: A slot that took at least one demand hit during residency resolves to class code 3, whatever its prefetch or dirty history. `ev_dirty` reports whether it was written.
- R6: A prefetch-filled slot with no demand hit resolves to class code 0, even if it was written. `ev_dirty` reports the write.
- R7: A fill with `fill_outer_hit`=1, or with `fill_cls`=4, marks the slot sticky. The slot resolves to class code 4 whatever else happens during that residency. A later fill with neither condition clears the mark.
- R8: Demand hits and writes to an empty slot are ignored. A fill that follows them starts clean and unreused.
- R9: When a fill and an eviction target the same index in one cycle, the eviction reports the old residency and the fill starts a fresh one.
- R10: When a hit or write targets the same index as an eviction (without a fill) in one cycle, the eviction reports the state from before that cycle, and the slot is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Fill event strobe |
| fill_line | input | IW | Slot index of the fill |
| fill_outer_hit | input | 1 | Fill data came from a last-level hit |
| fill_cls | input | 3 | Class value carried with the fill data |
| fill_pf | input | 1 | Fill was issued by a prefetch |
| hit_en | input | 1 | Demand hit strobe |
| hit_line | input | IW | Slot index of the demand hit |
| wr_en | input | 1 | Write strobe (sets dirty) |
| wr_line | input | IW | Slot index of the write |
| ev_en | input | 1 | Eviction request strobe |
| ev_line_in | input | IW | Slot index being evicted |
| ev_valid | output | 1 | One-cycle pulse: resolved eviction present |
| ev_line | output | IW | Slot index of the resolved eviction |
| ev_cls | output | 3 | Resolved reuse class code (0..4) |
| ev_dirty | output | 1 | Evicted line was dirty |

IW is log2 of the parameter LINES, which must be a power of two.

## Verification
Slot state changes at the clock edge that samples an event. The eviction result passes through one output register, so it appears exactly one edge after the request. The bench drives every event on the falling edge. It then waits for the next rising edge and samples one nanosecond after it. At that point it compares all four eviction outputs against a bench model that resolved the old residency at drive time. Each step therefore checks the result of the request made in that same step. The check on the following idle step confirms that the pulse has ended.

// File: rtl/rct_pkg.sv
package rct_pkg;

    typedef enum logic [1:0] {
        LN_EMPTY  = 2'd0,
        LN_PLAIN  = 2'd1,
        LN_PREF   = 2'd2,
        LN_REUSED = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        RC_C0 = 3'd0,
        RC_C1 = 3'd1,
        RC_C2 = 3'd2,
        RC_C3 = 3'd3,
        RC_C4 = 3'd4
    } reuse_cls_e;

    localparam int CLS_W = 3;

endpackage

// File: rtl/rct_line_fsm.sv
module rct_line_fsm
    import rct_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fill_go,
    input  logic     fill_pf,
    input  logic     fill_stk,
    input  logic     hit_go,
    input  logic     wr_go,
    input  logic     ev_go,
    output line_st_e st_q,
    output logic     dirty_q,
    output logic     stk_q
);

    line_st_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LN_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: install > retire > reuse > hold
    always_comb begin
        st_d = st_q;
        if (fill_go) begin
            st_d = fill_pf ? LN_PREF : LN_PLAIN;
        end else if (ev_go) begin
            st_d = LN_EMPTY;
        end else begin
            unique case (st_q)
                LN_EMPTY:  st_d = LN_EMPTY;
                LN_PLAIN:  st_d = hit_go ? LN_REUSED : LN_PLAIN;
                LN_PREF:   st_d = hit_go ? LN_REUSED : LN_PREF;
                LN_REUSED: st_d = LN_REUSED;
                default:   st_d = LN_EMPTY;
            endcase
        end
    end

    // per-slot attribute bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
            stk_q   <= 1'b0;
        end else if (fill_go) begin
            dirty_q <= 1'b0;
            stk_q   <= fill_stk;
        end else if (ev_go) begin
            dirty_q <= 1'b0;
            stk_q   <= 1'b0;
        end else if (wr_go && (st_q != LN_EMPTY)) begin
            dirty_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rct_class_resolve.sv
module rct_class_resolve
    import rct_pkg::*;
(
    input  line_st_e   st,
    input  logic       dirty,
    input  logic       stk,
    output logic       vld,
    output reuse_cls_e cls
);

    always_comb begin
        vld = (st != LN_EMPTY);
        cls = RC_C1;
        if (stk) begin
            cls = RC_C4;
        end else begin
            unique case (st)
                LN_EMPTY:  cls = RC_C1;
                LN_REUSED: cls = RC_C3;
                LN_PREF:   cls = RC_C0;
                LN_PLAIN:  cls = dirty ? RC_C2 : RC_C1;
                default:   cls = RC_C1;
            endcase
        end
    end

endmodule

// File: rtl/rct_evict_reg.sv
module rct_evict_reg
    import rct_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [IW-1:0]    line_in,
    input  reuse_cls_e       cls_in,
    input  logic             dirty_in,
    output logic             vld_q,
    output logic [IW-1:0]    line_q,
    output logic [CLS_W-1:0] cls_q,
    output logic             dirty_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            line_q  <= '0;
            cls_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            vld_q <= cap;
            if (cap) begin
                line_q  <= line_in;
                cls_q   <= cls_in;
                dirty_q <= dirty_in;
            end
        end
    end

endmodule

// File: rtl/reuse_class_tracker.sv
module reuse_class_tracker
    import rct_pkg::*;
#(
    parameter int LINES = 64,
    localparam int IW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IW-1:0]    fill_line,
    input  logic             fill_outer_hit,
    input  logic [2:0]       fill_cls,
    input  logic             fill_pf,
    input  logic             hit_en,
    input  logic [IW-1:0]    hit_line,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_line,
    input  logic             ev_en,
    input  logic [IW-1:0]    ev_line_in,
    output logic             ev_valid,
    output logic [IW-1:0]    ev_line,
    output logic [2:0]       ev_cls,
    output logic             ev_dirty
);

    line_st_e st_a    [LINES];
    logic     dirty_a [LINES];
    logic     stk_a   [LINES];

    logic fill_stk;
    assign fill_stk = fill_outer_hit || (fill_cls == 3'(RC_C4));

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic fgo, hgo, wgo, ego;
        assign fgo = fill_en && (fill_line  == IW'(i));
        assign hgo = hit_en  && (hit_line   == IW'(i));
        assign wgo = wr_en   && (wr_line    == IW'(i));
        assign ego = ev_en   && (ev_line_in == IW'(i));

        rct_line_fsm u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill_go  (fgo),
            .fill_pf  (fill_pf),
            .fill_stk (fill_stk),
            .hit_go   (hgo),
            .wr_go    (wgo),
            .ev_go    (ego),
            .st_q     (st_a[i]),
            .dirty_q  (dirty_a[i]),
            .stk_q    (stk_a[i])
        );
    end

    line_st_e   sel_st;
    logic       sel_dirty;
    logic       sel_stk;
    logic       sel_vld;
    reuse_cls_e sel_cls;

    assign sel_st    = st_a[ev_line_in];
    assign sel_dirty = dirty_a[ev_line_in];
    assign sel_stk   = stk_a[ev_line_in];

    rct_class_resolve u_resolve (
        .st    (sel_st),
        .dirty (sel_dirty),
        .stk   (sel_stk),
        .vld   (sel_vld),
        .cls   (sel_cls)
    );

    rct_evict_reg #(.IW(IW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (ev_en && sel_vld),
        .line_in  (ev_line_in),
        .cls_in   (sel_cls),
        .dirty_in (sel_dirty),
        .vld_q    (ev_valid),
        .line_q   (ev_line),
        .cls_q    (ev_cls),
        .dirty_q  (ev_dirty)
    );

endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
    parameter int LINES = 64,
    localparam int IW = $clog2(LINES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_en,
    input logic [IW-1:0] ev_line_in,
    input logic          ev_valid,
    input logic [IW-1:0] ev_line,
    input logic [2:0]    ev_cls,
    input logic          ev_dirty
);

    // R1: reset keeps the output quiet
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !ev_valid);

    // R2: a pulse needs a request one cycle earlier
    p_pulse_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(ev_en));

    // R2: the pulse carries the requested index
    p_pulse_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> ev_line == $past(ev_line_in));

    // R2: no request, no pulse
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_en |=> !ev_valid);

    // R3: class code 1 is only reported clean
    p_code1_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_cls == 3'd1) |-> !ev_dirty);

    // R4: class code 2 is only reported dirty
    p_code2_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_cls == 3'd2) |-> ev_dirty);

    // R7: no code above 4
    p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> ev_cls <= 3'd4);

endmodule

bind reuse_class_tracker rct_checker #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_en      (ev_en),
    .ev_line_in (ev_line_in),
    .ev_valid   (ev_valid),
    .ev_line    (ev_line),
    .ev_cls     (ev_cls),
    .ev_dirty   (ev_dirty)
);

// File: tb/reuse_class_tracker_bench.sv
`timescale 1ns/1ps
module reuse_class_tracker_bench;

    localparam int LINES = 64;
    localparam int IW = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_en = 0, fill_outer_hit = 0, fill_pf = 0;
    logic [2:0]    fill_cls = 0;
    logic [IW-1:0] fill_line = 0, hit_line = 0, wr_line = 0, ev_line_in = 0;
    logic          hit_en = 0, wr_en = 0, ev_en = 0;
    logic          ev_valid, ev_dirty;
    logic [IW-1:0] ev_line;
    logic [2:0]    ev_cls;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of each slot
    bit m_v [LINES];
    bit m_h [LINES];
    bit m_p [LINES];
    bit m_d [LINES];
    bit m_s [LINES];

    always #2 clk = ~clk;

    reuse_class_tracker #(.LINES(LINES)) u_reuse_class_tracker (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_line(fill_line), .fill_outer_hit(fill_outer_hit),
        .fill_cls(fill_cls), .fill_pf(fill_pf),
        .hit_en(hit_en), .hit_line(hit_line),
        .wr_en(wr_en), .wr_line(wr_line),
        .ev_en(ev_en), .ev_line_in(ev_line_in),
        .ev_valid(ev_valid), .ev_line(ev_line), .ev_cls(ev_cls), .ev_dirty(ev_dirty)
    );

    function automatic int exp_cls(bit h, bit p, bit d, bit s);
        if (s) return 4;
        if (h) return 3;
        if (p) return 0;
        if (d) return 2;
        return 1;
    endfunction

    function automatic string tag_of(bit v, int c);
        if (!v) return "R8";
        case (c)
            4: return "R7";
            3: return "R5";
            0: return "R6";
            2: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic step(input bit f, input int fl, input bit fo, input int fc, input bit fp,
                        input bit h, input int hl, input bit w, input int wl,
                        input bit e, input int el, input string tag);
        bit xv, xd;
        int xc;
        string t;
        fill_en = f; fill_line = IW'(fl); fill_outer_hit = fo; fill_cls = 3'(fc); fill_pf = fp;
        hit_en = h; hit_line = IW'(hl); wr_en = w; wr_line = IW'(wl);
        ev_en = e; ev_line_in = IW'(el);
        xv = e && m_v[el];
        xc = exp_cls(m_h[el], m_p[el], m_d[el], m_s[el]);
        xd = m_d[el];
        // model update: hit/write on untouched valid slots
        if (h && m_v[hl] && !(f && fl == hl) && !(e && el == hl)) m_h[hl] = 1;
        if (w && m_v[wl] && !(f && fl == wl) && !(e && el == wl)) m_d[wl] = 1;
        if (e) begin
            m_v[el] = 0; m_h[el] = 0; m_p[el] = 0; m_d[el] = 0; m_s[el] = 0;
        end
        if (f) begin
            m_v[fl] = 1; m_h[fl] = 0; m_p[fl] = fp; m_d[fl] = 0;
            m_s[fl] = fo || (fc == 4);
        end
        @(posedge clk);
        #1;
        t = (tag == "") ? tag_of(xv, xc) : tag;
        checks++;
        if (ev_valid !== xv ||
            (xv && (ev_line !== IW'(el) || ev_cls !== 3'(xc) || ev_dirty !== xd))) begin
            errors++;
            $display("FAIL %s: got v=%0d line=%0d cls=%0d dirty=%0d expected v=%0d line=%0d cls=%0d dirty=%0d",
                     t, ev_valid, ev_line, ev_cls, ev_dirty, xv, el, xc, xd);
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_v[i] = 0; m_h[i] = 0; m_p[i] = 0; m_d[i] = 0; m_s[i] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        checks++;
        if (ev_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got ev_valid=%0d expected 0 in reset", ev_valid);
        end
        rst_n = 1'b1;
        // R1: eviction of a never-filled slot
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R1");
        // R3 then R2 pulse ends
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R3");
        idle("R2");
        // R4 dirty demand line
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, "R4");
        // R5 prefetched then demanded, and written
        step(1, 3, 0, 0, 1, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 1, 3, 1, 3, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R5");
        // R6 prefetched, written, never demanded
        step(1, 4, 0, 0, 1, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, "R6");
        // R7 outer hit fill, class-4 fill, then plain refill clears
        step(1, 5, 1, 1, 0, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 1, 5, 1, 5, 0, 0, "");
        step(1, 6, 0, 4, 1, 0, 0, 0, 0, 1, 5, "R7");
        step(1, 5, 0, 2, 0, 0, 0, 0, 0, 1, 6, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, "R7");
        // R8 hit and write to an empty slot are dropped
        step(0, 0, 0, 0, 0, 1, 7, 1, 7, 0, 0, "");
        step(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, "R8");
        // R9 fill and evict same slot same cycle
        step(1, 8, 0, 0, 0, 0, 0, 1, 8, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 1, 8, 0, 0, "");
        step(1, 8, 0, 0, 1, 0, 0, 0, 0, 1, 8, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8, "R9");
        // R10 hit and evict same slot same cycle
        step(1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 1, 9, 1, 9, 1, 9, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 9, "R10");
        // constrained random traffic over a few slots to force collisions
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 100);
            step(r < 45, int'($urandom % 8), ($urandom % 4) == 0, int'($urandom % 5), ($urandom % 3) == 0,
                 ($urandom % 3) == 0, int'($urandom % 8),
                 ($urandom % 4) == 0, int'($urandom % 8),
                 ($urandom % 3) == 0, int'($urandom % 8), "");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule